// File: doc/BRIEF.md
# Serial Receiver Wakeup and Idle Detector

This block holds the receive-side control logic of an asynchronous serial port. A bit sampler ahead of it sends one strobe for every received bit time. The strobe carries the sampled line level and marks the bit as a start bit or a stop bit where that applies. A data shifter sends a strobe when a complete character is ready, together with the character itself. The sampler and the shifter are outside this block.

From these inputs the block does three things:
- It counts runs of logic 1s and recognises idle-line characters.
- It checks the parity of each accepted character.
- It runs a sleep state that suppresses character reception until a wakeup condition occurs.

Software-style controls are plain input pins:
- character length (8 or 9 data bits)
- wakeup mode (address mark or idle line)
- idle counting origin (after the start bit or after the stop bit)
- parity enable and parity sense

All results are registered and appear one clock after the strobe that causes them.

Top module: `rx_wake_idle_ctrl`

## Requirements
- R1: While reset is asserted and after reset, the outputs are as follows. `idle_o`, `data_rdy_o`, `par_err_o`, `wake_o` and `asleep_o` are 0. The run counter is cleared, so the first idle after reset needs a full frame of 1s. The detector starts armed, with counting enabled.
- R2: A frame is 1 start bit, plus 8 data bits (`len9`=0) or 9 data bits (`len9`=1), plus 1 stop bit. That is 10 or 11 bits. `idle_o` pulses high for one cycle, one clock after the bit strobe that brings the count of consecutive counted 1s to the frame length. A counted 0 clears the count.
- R3: Idle is reported only once per run of 1s. A further report is possible only after a strobe marked as a start bit, which also clears the count.
- R4: With `idle_after_stop`=0, every non-start bit after a start bit counts, including data bits and the stop bit. An all-ones 8-bit character followed by a single 1 bit is therefore reported as idle.
- R5: With `idle_after_stop`=1, counting stops at a start bit and resumes with the bit after the stop-marked bit. The stop bit itself is not counted.
- R6: On `char_done`, an accepted character produces a one-cycle `data_rdy_o` pulse. `par_err_o` is 1 under these conditions:
  - `par_en` is 1;
  - the XOR of the active data bits (bits 7..0, or 8..0 when `len9`=1) differs from `par_odd`.
  Setting `par_odd`=1 selects odd parity; `par_odd`=0 selects even parity.
- R7: The parity sense is taken in the cycle of `char_done`. A change of `par_odd` during a reception therefore decides the result for that character and can flag a parity error.
- R8: A `sleep_req` pulse sets `asleep_o` in the next cycle. While asleep, a character that does not wake the block produces neither `data_rdy_o` nor `par_err_o`.
- R9: With `wake_sel`=1, a character whose most significant active bit is 1, completed while asleep, has these effects:
  - `wake_o` pulses;
  - `asleep_o` clears;
  - the character itself is accepted, with `data_rdy_o` and parity checked.
- R10: With `wake_sel`=0, an idle detection while asleep pulses `wake_o` together with `idle_o` and clears `asleep_o`. Characters with a most significant bit of 1 do not wake the block in this mode.
- R11: `len9` selects the most significant active bit: bit 7 when 0, bit 8 when 1. Bit 8 is ignored for parity and for address marks in 8-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Sampled receive line level, valid with `bit_stb` |
| bit_stb | input | 1 | One-cycle strobe per received bit time |
| start_mark | input | 1 | With `bit_stb`: this bit is a start bit |
| stop_mark | input | 1 | With `bit_stb`: this bit is a stop bit |
| char_done | input | 1 | One-cycle strobe: a character has been received |
| char_data | input | WIDE_BITS (9) | Received character, LSB first order already resolved |
| len9 | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| wake_sel | input | 1 | 1 = address-mark wakeup, 0 = idle-line wakeup |
| idle_after_stop | input | 1 | 1 = idle count begins after stop bit, 0 = after start bit |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| sleep_req | input | 1 | Pulse: enter the sleep state |
| idle_o | output | 1 | Idle character detected (one-cycle pulse) |
| data_rdy_o | output | 1 | Character accepted (one-cycle pulse) |
| par_err_o | output | 1 | Parity error on the accepted character |
| wake_o | output | 1 | Wakeup occurred (one-cycle pulse) |
| asleep_o | output | 1 | Sleep state |

## Verification
Every result is due exactly one clock after its cause:
- the idle pulse after the bit strobe that completes the run;
- the ready and parity pulses after `char_done`;
- the wake pulse after the waking character or idle bit;
- the sleep state after `sleep_req`.

The bench changes inputs on falling edges. Each strobe lasts one cycle, and the bench reads the outputs at the following falling edge, after the single register stage. Counting and suppression are checked by keeping a running total of idle pulses across a stretch of bit strobes and comparing it at set points in the sequence.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   typedef enum logic {
      WAKE_ON_IDLE = 1'b0,
      WAKE_ON_MARK = 1'b1
   } wake_mode_e;

   // Bits in one frame: start + data + stop
   function automatic int frame_bits(input int data_bits, input int stop_bits);
      return 1 + data_bits + stop_bits;
   endfunction

endpackage

// File: rtl/rxw_idle_det.sv
module rxw_idle_det
   import rxw_pkg::*;
#(
   parameter int NARROW_BITS = 8,
   parameter int STOP_BITS   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_line,
   input  logic bit_stb,
   input  logic start_mark,
   input  logic stop_mark,
   input  logic len9,
   input  logic idle_after_stop,
   output logic idle_hit,
   output logic idle_q
);
   localparam int SHORT_FRAME = frame_bits(NARROW_BITS, STOP_BITS);
   localparam int LONG_FRAME  = frame_bits(NARROW_BITS + 1, STOP_BITS);
   localparam int CW          = $clog2(LONG_FRAME + 1);
   localparam logic [CW-1:0] SHORT_C = CW'(SHORT_FRAME);
   localparam logic [CW-1:0] LONG_C  = CW'(LONG_FRAME);

   generate
      if (NARROW_BITS < 5) begin : g_bad_width
         $error("rxw_idle_det: NARROW_BITS must be at least 5");
      end
      if (STOP_BITS < 1) begin : g_bad_stop
         $error("rxw_idle_det: STOP_BITS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run_q, run_d, run_inc, frame_len;
   logic          armed_q, armed_d;
   logic          cnt_en_q, cnt_en_d;

   assign frame_len = len9 ? LONG_C : SHORT_C;
   assign run_inc   = run_q + CW'(1);

   always_comb begin
      run_d    = run_q;
      armed_d  = armed_q;
      cnt_en_d = cnt_en_q;
      idle_hit = 1'b0;
      if (bit_stb) begin
         if (start_mark) begin
            run_d    = '0;
            armed_d  = 1'b1;
            cnt_en_d = ~idle_after_stop;
         end else begin
            if (cnt_en_q) begin
               if (rx_line) begin
                  if (run_q < frame_len) run_d = run_inc;
               end else begin
                  run_d = '0;
               end
               if (rx_line && armed_q && (run_inc == frame_len)) begin
                  idle_hit = 1'b1;
                  armed_d  = 1'b0;
               end
            end
            if (stop_mark) cnt_en_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= '0;
         armed_q  <= 1'b1;
         cnt_en_q <= 1'b1;
         idle_q   <= 1'b0;
      end else begin
         run_q    <= run_d;
         armed_q  <= armed_d;
         cnt_en_q <= cnt_en_d;
         idle_q   <= idle_hit;
      end
   end

   // R3: an idle report never repeats on the next cycle
   a_r3_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
      idle_q |=> !idle_q);
   // R3: a start bit clears the run and re-arms
   a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && start_mark) |=> (run_q == '0) && armed_q);
   // R5: after-stop counting holds off data bits
   a_r5_no_count_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && start_mark && idle_after_stop) |=> !cnt_en_q);
   // R2: the run never passes the longest frame
   a_r2_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= LONG_C);

endmodule

// File: rtl/rxw_parity.sv
module rxw_parity #(
   parameter int WIDE_BITS = 9
) (
   input  logic [WIDE_BITS-1:0] data,
   input  logic                 len9,
   input  logic                 par_en,
   input  logic                 par_odd,
   output logic                 msb,
   output logic                 err
);
   generate
      if (WIDE_BITS < 6) begin : g_bad_width
         $error("rxw_parity: WIDE_BITS must be at least 6");
      end
   endgenerate

   logic [WIDE_BITS-1:0] active;

   generate
      for (genvar i = 0; i < WIDE_BITS; i++) begin : g_mask
         if (i == WIDE_BITS - 1) begin : g_top
            assign active[i] = data[i] & len9;
         end else begin : g_low
            assign active[i] = data[i];
         end
      end
   endgenerate

   assign msb = len9 ? data[WIDE_BITS-1] : data[WIDE_BITS-2];
   assign err = par_en & ((^active) ^ par_odd);

endmodule

// File: rtl/rxw_sleep.sv
module rxw_sleep
   import rxw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       char_done,
   input  logic       msb,
   input  logic       par_bad,
   input  logic       idle_hit,
   input  wake_mode_e wake_mode,
   output logic       asleep_q,
   output logic       rdy_q,
   output logic       err_q,
   output logic       wake_q
);
   logic wake_now, accept;

   always_comb begin
      if (wake_mode == WAKE_ON_MARK) wake_now = asleep_q & char_done & msb;
      else                           wake_now = asleep_q & idle_hit;
      accept = char_done & (~asleep_q | wake_now);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         asleep_q <= 1'b0;
         rdy_q    <= 1'b0;
         err_q    <= 1'b0;
         wake_q   <= 1'b0;
      end else begin
         asleep_q <= sleep_req | (asleep_q & ~wake_now);
         rdy_q    <= accept;
         err_q    <= accept & par_bad;
         wake_q   <= wake_now;
      end
   end

   // R8: no character is delivered while asleep unless it woke the block
   a_r8_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q |-> (!$past(asleep_q) || wake_q));
   // R6: a parity error only accompanies an accepted character
   a_r6_err_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> rdy_q);
   // R9: a wakeup leaves the block awake unless sleep was requested again
   a_r9_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_q && !$past(sleep_req)) |-> !asleep_q);
   // R8: a sleep request always takes effect
   a_r8_sleep_sets: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> asleep_q);

endmodule

// File: rtl/rx_wake_idle_ctrl.sv
module rx_wake_idle_ctrl
   import rxw_pkg::*;
#(
   parameter int WIDE_BITS = 9,
   parameter int STOP_BITS = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_line,
   input  logic                 bit_stb,
   input  logic                 start_mark,
   input  logic                 stop_mark,
   input  logic                 char_done,
   input  logic [WIDE_BITS-1:0] char_data,
   input  logic                 len9,
   input  logic                 wake_sel,
   input  logic                 idle_after_stop,
   input  logic                 par_en,
   input  logic                 par_odd,
   input  logic                 sleep_req,
   output logic                 idle_o,
   output logic                 data_rdy_o,
   output logic                 par_err_o,
   output logic                 wake_o,
   output logic                 asleep_o
);
   localparam int NARROW_BITS = WIDE_BITS - 1;

   logic       idle_hit, msb, par_bad;
   wake_mode_e wake_mode;

   assign wake_mode = wake_mode_e'(wake_sel);

   rxw_idle_det #(
      .NARROW_BITS (NARROW_BITS),
      .STOP_BITS   (STOP_BITS)
   ) u_idle (
      .clk             (clk),
      .rst_n           (rst_n),
      .rx_line         (rx_line),
      .bit_stb         (bit_stb),
      .start_mark      (start_mark),
      .stop_mark       (stop_mark),
      .len9            (len9),
      .idle_after_stop (idle_after_stop),
      .idle_hit        (idle_hit),
      .idle_q          (idle_o)
   );

   rxw_parity #(
      .WIDE_BITS (WIDE_BITS)
   ) u_par (
      .data    (char_data),
      .len9    (len9),
      .par_en  (par_en),
      .par_odd (par_odd),
      .msb     (msb),
      .err     (par_bad)
   );

   rxw_sleep u_sleep (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .char_done (char_done),
      .msb       (msb),
      .par_bad   (par_bad),
      .idle_hit  (idle_hit),
      .wake_mode (wake_mode),
      .asleep_q  (asleep_o),
      .rdy_q     (data_rdy_o),
      .err_q     (par_err_o),
      .wake_q    (wake_o)
   );

   // R10: an idle-mode wakeup coincides with an idle report
   a_r10_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_o && !$past(wake_sel)) |-> idle_o);
   // R9: a mark-mode wakeup delivers the waking character
   a_r9_mark_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_o && $past(wake_sel)) |-> data_rdy_o);

endmodule

// File: tb/test_rx_wake_idle_ctrl.sv
`timescale 1ns/1ps
module test_rx_wake_idle_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1, bit_stb = 1'b0, start_mark = 1'b0, stop_mark = 1'b0;
   logic       char_done = 1'b0;
   logic [8:0] char_data = '0;
   logic       len9 = 1'b0, wake_sel = 1'b0, idle_after_stop = 1'b0;
   logic       par_en = 1'b0, par_odd = 1'b0, sleep_req = 1'b0;
   logic       idle_o, data_rdy_o, par_err_o, wake_o, asleep_o;

   int checks = 0;
   int errors = 0;
   int idle_seen = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rx_wake_idle_ctrl i_rx_wake_idle_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_stb(bit_stb),
      .start_mark(start_mark), .stop_mark(stop_mark), .char_done(char_done),
      .char_data(char_data), .len9(len9), .wake_sel(wake_sel),
      .idle_after_stop(idle_after_stop), .par_en(par_en), .par_odd(par_odd),
      .sleep_req(sleep_req), .idle_o(idle_o), .data_rdy_o(data_rdy_o),
      .par_err_o(par_err_o), .wake_o(wake_o), .asleep_o(asleep_o)
   );

   // {len9, par_en, par_odd, data[8:0], exp_rdy, exp_err}
   localparam logic [13:0] VEC [10] = '{
      {3'b000, 9'h0A5, 2'b10},
      {3'b010, 9'h003, 2'b10},
      {3'b010, 9'h007, 2'b11},
      {3'b011, 9'h007, 2'b10},
      {3'b011, 9'h081, 2'b11},
      {3'b110, 9'h100, 2'b11},
      {3'b111, 9'h100, 2'b10},
      {3'b010, 9'h100, 2'b10},
      {3'b101, 9'h1FF, 2'b10},
      {3'b110, 9'h1FF, 2'b11}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bit_in(input logic v, input logic st, input logic sp);
      @(negedge clk);
      rx_line = v; bit_stb = 1'b1; start_mark = st; stop_mark = sp;
      @(negedge clk);
      bit_stb = 1'b0; start_mark = 1'b0; stop_mark = 1'b0; rx_line = 1'b1;
      if (idle_o) idle_seen++;
   endtask

   task automatic ones(input int n);
      for (int i = 0; i < n; i++) bit_in(1'b1, 1'b0, 1'b0);
   endtask

   task automatic frame(input logic [8:0] d, input int n);
      bit_in(1'b0, 1'b1, 1'b0);
      for (int i = 0; i < n; i++) bit_in(d[i], 1'b0, 1'b0);
      bit_in(1'b1, 1'b0, 1'b1);
   endtask

   task automatic char_in(input logic [8:0] d);
      @(negedge clk);
      char_done = 1'b1; char_data = d;
      @(negedge clk);
      char_done = 1'b0;
   endtask

   task automatic sleep_pulse();
      @(negedge clk);
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 idle in reset", idle_o, 0);
      chk("R1 rdy in reset", data_rdy_o, 0);
      chk("R1 wake in reset", wake_o, 0);
      chk("R1 asleep in reset", asleep_o, 0);
      rst_n = 1'b1;

      // R2, R3: 8-bit frame of ones, counted from reset
      idle_seen = 0;
      ones(9);
      chk("R2 no idle before 10 ones", idle_seen, 0);
      bit_in(1'b1, 1'b0, 1'b0);
      chk("R2 idle on 10th one", idle_o, 1);
      @(negedge clk);
      chk("R2 idle lasts one cycle", idle_o, 0);
      ones(10);
      chk("R3 single idle per run", idle_seen, 1);

      // R2, R3: 9-bit mode needs 11, start re-arms
      len9 = 1'b1;
      idle_seen = 0;
      bit_in(1'b0, 1'b1, 1'b0);
      ones(10);
      chk("R2 no idle at 10 in 9-bit", idle_seen, 0);
      bit_in(1'b1, 1'b0, 1'b0);
      chk("R3 rearmed idle on 11th one", idle_o, 1);
      len9 = 1'b0;

      // R4: false idle when counting from the start bit
      frame(9'h0FF, 8);
      idle_seen = 0;
      bit_in(1'b1, 1'b0, 1'b0);
      chk("R4 false idle after FF char", idle_o, 1);

      // R5: counting from the stop bit
      idle_after_stop = 1'b1;
      frame(9'h0FF, 8);
      idle_seen = 0;
      ones(9);
      chk("R5 no idle after 9 ones past stop", idle_seen, 0);
      bit_in(1'b1, 1'b0, 1'b0);
      chk("R5 idle on 10th one past stop", idle_o, 1);
      idle_after_stop = 1'b0;

      // R6, R11: character table
      for (int k = 0; k < 10; k++) begin
         len9 = VEC[k][13]; par_en = VEC[k][12]; par_odd = VEC[k][11];
         char_in(VEC[k][10:2]);
         chk($sformatf("R6 rdy vec %0d", k), data_rdy_o, VEC[k][1]);
         chk($sformatf("R6 R11 parity vec %0d", k), par_err_o, VEC[k][0]);
      end
      @(negedge clk);
      chk("R6 rdy is a pulse", data_rdy_o, 0);

      // R7: parity sense changed mid reception
      len9 = 1'b0; par_en = 1'b1; par_odd = 1'b0;
      frame(9'h003, 8);
      par_odd = 1'b1;
      char_in(9'h003);
      chk("R7 sense change gives error", par_err_o, 1);

      // R8, R9, R11: address-mark wakeup
      par_odd = 1'b0; wake_sel = 1'b1;
      sleep_pulse();
      chk("R8 asleep after request", asleep_o, 1);
      char_in(9'h001);
      chk("R8 no rdy asleep", data_rdy_o, 0);
      chk("R8 no parity error asleep", par_err_o, 0);
      chk("R8 no wake on plain char", wake_o, 0);
      len9 = 1'b1;
      char_in(9'h080);
      chk("R11 bit7 not a mark in 9-bit", wake_o, 0);
      chk("R11 still asleep", asleep_o, 1);
      char_in(9'h100);
      chk("R9 wake on mark", wake_o, 1);
      chk("R9 mark char accepted", data_rdy_o, 1);
      chk("R9 mark char parity", par_err_o, 1);
      chk("R9 awake after mark", asleep_o, 0);
      len9 = 1'b0; par_en = 1'b0;

      // R10: idle-line wakeup
      wake_sel = 1'b0;
      frame(9'h000, 8);
      sleep_pulse();
      char_in(9'h080);
      chk("R10 mark ignored in idle mode", wake_o, 0);
      chk("R10 mark char suppressed", data_rdy_o, 0);
      idle_seen = 0;
      ones(8);
      chk("R10 no early wake", asleep_o, 1);
      bit_in(1'b1, 1'b0, 1'b0);
      chk("R10 wake on idle", wake_o, 1);
      chk("R10 idle with wake", idle_o, 1);
      chk("R10 awake after idle", asleep_o, 0);

      // R1: reset clears sleep
      sleep_pulse();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset clears sleep", asleep_o, 0);

      finish_run();
   end
endmodule